// File: doc/BRIEF.md
# Banked ROM Address Translator

This block converts processor addresses in the upper 32 KB (0x8000 to 0xFFFF) and pattern-table addresses (0x0000 to 0x1FFF) into flat addresses in larger program and pattern ROMs. A small register file holds two switchable 8 KB program bank numbers, six pattern bank numbers (two 2 KB and four 1 KB), and two mode bits. The processor side is cut into four 8 KB windows. Two of them are fixed to banks counted back from the end of the ROM. The pattern side is cut into one half built from two 2 KB banks and one half built from four 1 KB banks.

The total number of 8 KB program banks comes in on an input. It must be a power of two, and at least 2. The fixed banks are derived from it, and every program bank number wraps modulo it. Translation is purely combinational. Only the register writes are clocked, so a write changes the mapping of every access from the following cycle on.

Top module: `rom_bank_mapper`

## Requirements
- R1: After reset, every bank register and both mode bits are zero. With 32 program banks, window 0 therefore maps to bank 0, window 2 to bank 30, and pattern address 0x0000 to ROM address 0.
- R2: Window 3 (0xE000 to 0xFFFF) always maps to program bank N-1, where N is `prg_bank_count`, whatever the registers and mode hold.
- R3: With the program swap bit (mode bit 0) clear, windows 0, 1 and 2 map to switchable bank A, switchable bank B and bank N-2.
- R4: With the program swap bit set, windows 0, 1 and 2 map to bank N-2, switchable bank B and switchable bank A.
- R5: A program bank register keeps the low `PRG_BANK_W` bits of the write data. The bank that is used is that value modulo N.
- R6: With the pattern swap bit (mode bit 1) clear, 0x0000 to 0x0FFF uses the 2 KB banks (the first for 0x0000, the second for 0x0800), and 0x1000 to 0x1FFF uses 1 KB banks 0 to 3 in ascending address order.
- R7: With the pattern swap bit set, the two halves trade places: the 1 KB banks cover 0x0000 to 0x0FFF and the 2 KB banks cover 0x1000 to 0x1FFF, in the same internal order.
- R8: For a 2 KB bank, bit 0 of the register is ignored and pattern address bit 10 selects the 1 KB half, giving ROM bank (reg & ~1) | a[10].
- R9: The low 13 address bits pass to the program ROM address unchanged, and the low 10 bits pass to the pattern ROM address unchanged. `prg_rom_sel` equals cpu_addr[15].
- R10: When `reg_we` is high at a rising clock edge, `reg_sel` picks the target: 0 and 1 are the 2 KB pattern banks, 2 to 5 are the 1 KB pattern banks 0 to 3, 6 is program bank A, 7 is program bank B, and 8 is the mode (bit 0 program swap, bit 1 pattern swap). Selectors 9 to 15, and any cycle with `reg_we` low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register selector (see R10) |
| reg_wdata | input | DATA_W | Write data |
| prg_bank_count | input | PRG_BANK_W+1 | Number of 8 KB program banks, a power of two |
| cpu_addr | input | 16 | Processor address |
| ppu_addr | input | 13 | Pattern-table address |
| prg_rom_sel | output | 1 | High when cpu_addr falls in 0x8000 to 0xFFFF |
| prg_rom_addr | output | PRG_BANK_W+13 | Program ROM byte address |
| chr_rom_addr | output | CHR_BANK_W+10 | Pattern ROM byte address |

## Verification
The bench sweeps every program window under both swap settings for every legal bank count from 2 to 32. It writes bank values larger than the count, so a design that forgot the modulo wrap, or that derived N-2 or N-1 at the wrong width, would put a bank past the end of the ROM. It visits all eight 1 KB slices of pattern space, at both edge offsets and in both swap modes. This catches a design that swapped the wrong half, reversed the bank order, or kept bit 0 of a 2 KB register instead of replacing it with address bit 10. Writes to unused selectors and strobe-less writes are followed by a full re-probe of every window, so a decoder that aliased a selector would visibly move a mapping.

// File: rtl/rom_bank_mapper_pkg.sv
package rom_bank_mapper_pkg;

  typedef enum logic [3:0] {
    SEL_CHR2K_0 = 4'd0,
    SEL_CHR2K_1 = 4'd1,
    SEL_CHR1K_0 = 4'd2,
    SEL_CHR1K_1 = 4'd3,
    SEL_CHR1K_2 = 4'd4,
    SEL_CHR1K_3 = 4'd5,
    SEL_PRG_A   = 4'd6,
    SEL_PRG_B   = 4'd7,
    SEL_MODE    = 4'd8
  } map_sel_e;

  localparam int unsigned NUM_CHR_REGS = 6;

  typedef struct packed {
    logic chr_swap;
    logic prg_swap;
  } map_mode_t;

endpackage

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs
  import rom_bank_mapper_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 5,
  parameter int unsigned CHR_BANK_W = 8,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    we,
  input  logic [3:0]                              sel,
  input  logic [DATA_W-1:0]                       wdata,
  output logic [PRG_BANK_W-1:0]                   prg_a,
  output logic [PRG_BANK_W-1:0]                   prg_b,
  output logic [NUM_CHR_REGS-1:0][CHR_BANK_W-1:0] chr_bank,
  output map_mode_t                               mode
);

  logic [PRG_BANK_W-1:0] prg_a_q, prg_b_q, prg_a_d, prg_b_d;
  logic                  prg_a_en, prg_b_en, mode_en;
  map_mode_t             mode_q, mode_d;
  logic [NUM_CHR_REGS-1:0] chr_en;
  logic [NUM_CHR_REGS-1:0][CHR_BANK_W-1:0] chr_q;

  // Write decode and next-state values.
  always_comb begin
    prg_a_en = we && (sel == SEL_PRG_A);
    prg_b_en = we && (sel == SEL_PRG_B);
    mode_en  = we && (sel == SEL_MODE);
    prg_a_d  = wdata[PRG_BANK_W-1:0];
    prg_b_d  = wdata[PRG_BANK_W-1:0];
    mode_d   = map_mode_t'(wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_a_q <= '0;
    end else if (prg_a_en) begin
      prg_a_q <= prg_a_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_b_q <= '0;
    end else if (prg_b_en) begin
      prg_b_q <= prg_b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  for (genvar i = 0; i < NUM_CHR_REGS; i++) begin : g_chr
    logic [CHR_BANK_W-1:0] chr_d;
    always_comb begin
      chr_en[i] = we && (sel == 4'(i));
      chr_d     = wdata[CHR_BANK_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chr_q[i] <= '0;
      end else if (chr_en[i]) begin
        chr_q[i] <= chr_d;
      end
    end
  end

  assign prg_a    = prg_a_q;
  assign prg_b    = prg_b_q;
  assign chr_bank = chr_q;
  assign mode     = mode_q;

  // R10: a write to bank A lands on the next cycle
  assert_write_prg_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 4'd6) |=> (prg_a == $past(wdata[PRG_BANK_W-1:0])));

  // R10: unselected or strobe-less cycles keep the mode
  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && sel == 4'd8) |=> $stable(mode));

  // R10: at most one register is written per cycle
  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chr_en, prg_a_en, prg_b_en, mode_en}));

endmodule

// File: rtl/mapper_prg_xlate.sv
module mapper_prg_xlate #(
  parameter int unsigned PRG_BANK_W = 5
) (
  input  logic [1:0]             window,
  input  logic [12:0]            offset,
  input  logic [PRG_BANK_W-1:0]  bank_a,
  input  logic [PRG_BANK_W-1:0]  bank_b,
  input  logic [PRG_BANK_W:0]    bank_count,
  input  logic                   swap,
  output logic [PRG_BANK_W+12:0] rom_addr
);

  localparam int unsigned CNT_W = PRG_BANK_W + 1;

  logic [CNT_W-1:0]      last_full, second_full;
  logic [PRG_BANK_W-1:0] wrap_mask, last_bank, second_bank, raw_bank, bank;

  always_comb begin
    last_full   = bank_count - CNT_W'(1);
    second_full = bank_count - CNT_W'(2);
    wrap_mask   = last_full[PRG_BANK_W-1:0];
    last_bank   = last_full[PRG_BANK_W-1:0];
    second_bank = second_full[PRG_BANK_W-1:0];
    unique case (window)
      2'd0:    raw_bank = swap ? second_bank : bank_a;
      2'd1:    raw_bank = bank_b;
      2'd2:    raw_bank = swap ? bank_a : second_bank;
      default: raw_bank = last_bank;
    endcase
    bank     = raw_bank & wrap_mask;
    rom_addr = {bank, offset};
  end

endmodule

// File: rtl/mapper_chr_xlate.sv
module mapper_chr_xlate
  import rom_bank_mapper_pkg::*;
#(
  parameter int unsigned CHR_BANK_W = 8
) (
  input  logic [12:0]                             addr,
  input  logic [NUM_CHR_REGS-1:0][CHR_BANK_W-1:0] chr_bank,
  input  logic                                    swap,
  output logic [CHR_BANK_W+9:0]                   rom_addr
);

  logic                  in_1k_half;
  logic [CHR_BANK_W-1:0] reg_2k, bank_2k, bank_1k, bank;

  always_comb begin
    in_1k_half = addr[12] ^ swap;
    reg_2k     = chr_bank[addr[11]];
    bank_2k    = (reg_2k & ~CHR_BANK_W'(1)) | CHR_BANK_W'(addr[10]);
    bank_1k    = chr_bank[3'd2 + {1'b0, addr[11:10]}];
    bank       = in_1k_half ? bank_1k : bank_2k;
    rom_addr   = {bank, addr[9:0]};
  end

endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
  import rom_bank_mapper_pkg::*;
#(
  parameter int unsigned PRG_BANK_W = 5,
  parameter int unsigned CHR_BANK_W = 8,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [3:0]             reg_sel,
  input  logic [DATA_W-1:0]      reg_wdata,
  input  logic [PRG_BANK_W:0]    prg_bank_count,
  input  logic [15:0]            cpu_addr,
  input  logic [12:0]            ppu_addr,
  output logic                   prg_rom_sel,
  output logic [PRG_BANK_W+12:0] prg_rom_addr,
  output logic [CHR_BANK_W+9:0]  chr_rom_addr
);

  localparam int unsigned PRG_AW = PRG_BANK_W + 13;

  logic rst_meta, rst_sync_n;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [PRG_BANK_W-1:0]                   prg_a, prg_b;
  logic [NUM_CHR_REGS-1:0][CHR_BANK_W-1:0] chr_bank;
  map_mode_t                               mode;

  mapper_bank_regs #(
    .PRG_BANK_W(PRG_BANK_W),
    .CHR_BANK_W(CHR_BANK_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (reg_we),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .prg_a   (prg_a),
    .prg_b   (prg_b),
    .chr_bank(chr_bank),
    .mode    (mode)
  );

  mapper_prg_xlate #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
    .window    (cpu_addr[14:13]),
    .offset    (cpu_addr[12:0]),
    .bank_a    (prg_a),
    .bank_b    (prg_b),
    .bank_count(prg_bank_count),
    .swap      (mode.prg_swap),
    .rom_addr  (prg_rom_addr)
  );

  mapper_chr_xlate #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
    .addr    (ppu_addr),
    .chr_bank(chr_bank),
    .swap    (mode.chr_swap),
    .rom_addr(chr_rom_addr)
  );

  assign prg_rom_sel = cpu_addr[15];

  // R2: top window pinned to the final bank
  assert_last_window_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_addr[14:13] == 2'd3) |->
      ({1'b0, prg_rom_addr[PRG_AW-1:13]} == prg_bank_count - 1'b1));

  // R5: translated bank never exceeds the count
  assert_bank_in_range_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ({1'b0, prg_rom_addr[PRG_AW-1:13]} < prg_bank_count));

  // R4: window 1 follows bank B in both modes
  assert_window1_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_addr[14:13] == 2'd1) |->
      (prg_rom_addr[PRG_AW-1:13] == (prg_b & PRG_BANK_W'(prg_bank_count - 1'b1))));

  // R9: in-bank offsets pass straight through
  assert_offset_pass_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prg_rom_addr[12:0] == cpu_addr[12:0]) && (chr_rom_addr[9:0] == ppu_addr[9:0]));

  // R8: inside the 2 KB half, address bit 10 is the low bank bit
  assert_2k_half_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ppu_addr[12] == mode.chr_swap) |-> (chr_rom_addr[10] == ppu_addr[10]));

endmodule

// File: tb/rom_bank_mapper_bench.sv
module rom_bank_mapper_bench;

  localparam int unsigned PW = 5;
  localparam int unsigned CW = 8;

  logic            clk;
  logic            rst_n;
  logic            reg_we;
  logic [3:0]      reg_sel;
  logic [7:0]      reg_wdata;
  logic [PW:0]     prg_bank_count;
  logic [15:0]     cpu_addr;
  logic [12:0]     ppu_addr;
  logic            prg_rom_sel;
  logic [PW+12:0]  prg_rom_addr;
  logic [CW+9:0]   chr_rom_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rom_bank_mapper #(.PRG_BANK_W(PW), .CHR_BANK_W(CW), .DATA_W(8)) u_rom_bank_mapper (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .prg_bank_count(prg_bank_count),
    .cpu_addr      (cpu_addr),
    .ppu_addr      (ppu_addr),
    .prg_rom_sel   (prg_rom_sel),
    .prg_rom_addr  (prg_rom_addr),
    .chr_rom_addr  (chr_rom_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic write_reg(input logic [3:0] sel, input logic [7:0] data, input logic we);
    @(negedge clk);
    reg_we    = we;
    reg_sel   = sel;
    reg_wdata = data;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic check_prg(input string req, input int win, input int off, input int exp_bank);
    logic [PW+12:0] exp;
    cpu_addr = {1'b1, 2'(win), 13'(off)};
    #1;
    exp = {PW'(exp_bank), 13'(off)};
    checks++;
    if (prg_rom_addr !== exp || prg_rom_sel !== 1'b1) begin
      errors++;
      $display("FAIL %s prg win %0d off %h: got %h sel %b, expected %h sel 1",
               req, win, off, prg_rom_addr, prg_rom_sel, exp);
    end
  endtask

  task automatic check_chr(input string req, input int addr, input int exp_bank);
    logic [CW+9:0] exp;
    ppu_addr = 13'(addr);
    #1;
    exp = {CW'(exp_bank), 10'(addr)};
    checks++;
    if (chr_rom_addr !== exp) begin
      errors++;
      $display("FAIL %s chr addr %h: got %h, expected %h", req, addr, chr_rom_addr, exp);
    end
  endtask

  // Program banks currently programmed, and full expectation per window.
  int cur_a, cur_b, cur_n, cur_swap;

  function automatic int prg_expect(input int win);
    int sec;
    sec = (cur_n - 2) % cur_n;
    case (win)
      0:       return cur_swap ? sec : (cur_a % cur_n);
      1:       return cur_b % cur_n;
      2:       return cur_swap ? (cur_a % cur_n) : sec;
      default: return cur_n - 1;
    endcase
  endfunction

  task automatic sweep_prg(input string req);
    for (int w = 0; w < 4; w++) begin
      check_prg(w == 3 ? "R2" : req, w, 0, prg_expect(w));
      check_prg("R9", w, 13'h1FFF, prg_expect(w));
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    report();
  end

  initial begin
    rst_n          = 1'b0;
    reg_we         = 1'b0;
    reg_sel        = 4'd0;
    reg_wdata      = 8'd0;
    prg_bank_count = 6'd32;
    cpu_addr       = 16'h8000;
    ppu_addr       = 13'h0000;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1: reset state
    check_prg("R1", 0, 0, 0);
    check_prg("R1", 2, 0, 30);
    check_chr("R1", 13'h0000, 0);

    // Program windows for every legal bank count, both swap modes.
    for (int lg = 1; lg <= 5; lg++) begin
      cur_n = 1 << lg;
      prg_bank_count = 6'(cur_n);
      cur_a = 8'h13 + lg * 5;
      cur_b = 8'h2C + lg * 3;
      write_reg(4'd6, 8'(cur_a), 1'b1);
      write_reg(4'd7, 8'(cur_b), 1'b1);
      for (int s = 0; s < 2; s++) begin
        cur_swap = s;
        write_reg(4'd8, 8'(s), 1'b1);
        sweep_prg(s == 0 ? "R3" : "R4");
        check_prg("R5", 0, 13'h0ABC, prg_expect(0));
      end
    end

    // R10: ignored writes leave every program window unchanged
    write_reg(4'd9,  8'hFF, 1'b1);
    write_reg(4'd15, 8'hFF, 1'b1);
    write_reg(4'd6,  8'h05, 1'b0);
    write_reg(4'd8,  8'h00, 1'b0);
    sweep_prg("R10");

    // R10: a real write takes effect on the next access
    cur_a = 8'h0B;
    write_reg(4'd6, 8'(cur_a), 1'b1);
    check_prg("R10", 2, 0, prg_expect(2));

    // Pattern side: program all six banks, then sweep both modes.
    begin
      int r2k [2];
      int r1k [4];
      r2k[0] = 8'h35; r2k[1] = 8'h8A;
      r1k[0] = 8'h11; r1k[1] = 8'h42; r1k[2] = 8'hC3; r1k[3] = 8'hFE;
      for (int i = 0; i < 2; i++) write_reg(4'(i), 8'(r2k[i]), 1'b1);
      for (int i = 0; i < 4; i++) write_reg(4'(i + 2), 8'(r1k[i]), 1'b1);
      for (int s = 0; s < 2; s++) begin
        write_reg(4'd8, 8'(s << 1), 1'b1);
        for (int slot = 0; slot < 8; slot++) begin
          int half, bank;
          half = ((slot >> 2) & 1) ^ s;
          if (half == 0) bank = (r2k[(slot >> 1) & 1] & ~1) | (slot & 1);
          else           bank = r1k[slot & 3];
          check_chr(half == 0 ? "R8" : (s == 0 ? "R6" : "R7"), slot * 1024, bank);
          check_chr(s == 0 ? "R6" : "R7", slot * 1024 + 10'h3FF, bank);
        end
      end
      // R10: disabled and unused-selector writes keep the pattern mapping
      write_reg(4'd2, 8'h00, 1'b0);
      write_reg(4'd12, 8'h00, 1'b1);
      check_chr("R10", 13'h0000, r1k[0]);
    end

    report();
  end

endmodule